// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master with Event Interrupt

This block drives a serial link that has one clock line and one shared, bidirectional data line. A single transaction has three parts. First the block clocks out a programmed number of bits, taken from a stream of 32-bit words. Then it releases the data line for a turnaround. Last, it clocks in a programmed number of response bits and packs them into 32-bit words. After the read part the clock stays low while the block waits for the target to pull the data line high. That rising level is the target's event signal, and the block answers it with a one-tick interrupt pulse. Chip select, DMA and clock division are outside the block. The `tick` clock-enable strobe sets the engine rate, and the serial clock runs at half that rate.

Bit counts are given as count-minus-one. A fast-turnaround flag adds one extra clock-low tick before the first read sample, for use at the highest serial rates. A read-skip flag leaves out the turnaround and the read phase entirely.

Each state below lasts one tick unless noted. ST_IDLE moves to ST_WR_LO when start is seen. ST_WR_LO always moves to ST_WR_HI. From ST_WR_HI the block returns to ST_WR_LO while write bits remain. After the last write bit it goes to ST_TA_LO, or to ST_EV_WAIT when skip is set. ST_TA_LO moves to ST_TA_HI. ST_TA_HI moves to ST_TA_EXTRA in fast mode and to ST_RD_LO otherwise. ST_TA_EXTRA moves to ST_RD_LO. ST_RD_LO always moves to ST_RD_HI. From ST_RD_HI the block returns to ST_RD_LO while read bits remain, and goes to ST_EV_WAIT after the last one. ST_EV_WAIT stays put until the data line is high, then moves to ST_IRQ. ST_IRQ returns to ST_IDLE.

Top module: `spi3w_master`

## Requirements
- R1: After reset and between transactions, sclk is 0, dio_oe is 0, irq is 0 and busy is 0.
- R2: The write phase drives wr_bits_m1+1 bits, MSB first, through consecutive transmit words. dio_oe stays high for exactly 2*(wr_bits_m1+1) ticks. dio_out changes only while sclk is low and is stable during every sclk-high tick.
- R3: The block latches the first transmit word on the tick that accepts start, and a new word after every 32 bits shifted out, but never after the last write bit. tx_req pulses for one clk cycle in the cycle after each latch, so a transaction raises ceil((wr_bits_m1+1)/32) pulses.
- R4: After the last write bit, dio_oe falls while sclk is low, and one sclk-high tick follows. The sclk-low gap between that high tick and the first read high tick is 1 tick, or 2 ticks when fast_ta is 1.
- R5: Without skip, the read phase gives rd_bits_m1+1 sclk-high ticks after the turnaround high tick. dio_in is sampled at the end of the low tick of each read bit.
- R6: Received bits are packed MSB first (the first bit lands in bit 31) into 32-bit words. A word is output with a one-cycle rx_push when it is full, and a partial word at the end of the read phase is pushed left-justified with zeros below.
- R7: When rd_skip is 1 at start, no turnaround or read clocks occur and no rx_push occurs. The block goes straight to the event wait after the write phase.
- R8: In the event wait, sclk stays low until a tick edge finds dio_in high. irq is then 1 for exactly one tick, and the block returns to idle. With a tick on every clk cycle, irq appears one cycle after dio_in rises.
- R9: start is accepted only in idle. A start held during a transaction does not begin a second transaction.
- R10: State and outputs change only on clk edges where tick is 1. Each bit takes two ticks, so with a tick every N clk cycles each sclk-high phase lasts N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable strobe; one engine step per high cycle |
| start | input | 1 | Request a transaction (taken in idle on a tick) |
| wr_bits_m1 | input | CNT_W | Write bit count minus one |
| rd_bits_m1 | input | CNT_W | Read bit count minus one |
| rd_skip | input | 1 | Skip turnaround and read phase |
| fast_ta | input | 1 | Insert one extra sclk-low tick before the first read sample |
| tx_word | input | WORD_W | Current transmit word from the host stream |
| tx_req | output | 1 | Pulse: tx_word was latched, present the next word |
| rx_word | output | WORD_W | Received word |
| rx_push | output | 1 | Pulse: rx_word is valid |
| busy | output | 1 | Transaction in progress |
| irq | output | 1 | One-tick interrupt after the target event |
| sclk | output | 1 | Serial clock |
| dio_out | output | 1 | Data line output value |
| dio_oe | output | 1 | Data line output enable |
| dio_in | input | 1 | Data line input value |

## Verification
The bench sweeps write and read lengths that sit on and around the 32-bit word boundary, in both turnaround modes. This catches a design that fetches one transmit word too many at an exact multiple of 32, or that drops or misplaces the partial last receive word. A behavioural target echoes a known pattern and counts sclk edges. An off-by-one in the minus-one counters would show up as a wrong number of write or read clocks, and a fast mode that failed to lengthen the turnaround would show up as a 1-tick gap. Further runs raise the event after varying delays, hold start while the block is busy, skip the read phase, and slow the tick to one in three cycles. A design that fired early or held irq too long, restarted on a held start, or changed state between ticks would fail these runs.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_TA_LO,
        ST_TA_HI,
        ST_TA_EXTRA,
        ST_RD_LO,
        ST_RD_HI,
        ST_EV_WAIT,
        ST_IRQ
    } phase_e;

    typedef struct packed {
        logic tx_load;
        logic tx_adv;
        logic rx_smp;
        logic rx_flush;
    } dp_ctl_t;

endpackage

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
    import spi3w_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] wr_m1,
    input  logic [CNT_W-1:0] rd_m1,
    input  logic             rd_skip,
    input  logic             fast_ta,
    input  logic             dio_in,
    output dp_ctl_t          ctl,
    output logic             sclk,
    output logic             dio_oe,
    output logic             irq,
    output logic             busy
);

    phase_e           st, st_nx;
    logic [CNT_W-1:0] wcnt, wcnt_nx;
    logic [CNT_W-1:0] rcnt, rcnt_nx;
    logic             skip_q, fast_q;

    // next state, counters and datapath strobes (all qualified by tick)
    always_comb begin
        st_nx   = st;
        wcnt_nx = wcnt;
        rcnt_nx = rcnt;
        ctl     = '0;
        if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st_nx       = ST_WR_LO;
                        wcnt_nx     = wr_m1;
                        rcnt_nx     = rd_m1;
                        ctl.tx_load = 1'b1;
                    end
                end
                ST_WR_LO: st_nx = ST_WR_HI;
                ST_WR_HI: begin
                    if (wcnt == '0) begin
                        st_nx = skip_q ? ST_EV_WAIT : ST_TA_LO;
                    end else begin
                        wcnt_nx    = wcnt - 1'b1;
                        ctl.tx_adv = 1'b1;
                        st_nx      = ST_WR_LO;
                    end
                end
                ST_TA_LO:    st_nx = ST_TA_HI;
                ST_TA_HI:    st_nx = fast_q ? ST_TA_EXTRA : ST_RD_LO;
                ST_TA_EXTRA: st_nx = ST_RD_LO;
                ST_RD_LO: begin
                    ctl.rx_smp = 1'b1;
                    st_nx      = ST_RD_HI;
                end
                ST_RD_HI: begin
                    if (rcnt == '0) begin
                        ctl.rx_flush = 1'b1;
                        st_nx        = ST_EV_WAIT;
                    end else begin
                        rcnt_nx = rcnt - 1'b1;
                        st_nx   = ST_RD_LO;
                    end
                end
                ST_EV_WAIT: begin
                    if (dio_in) st_nx = ST_IRQ;
                end
                ST_IRQ:  st_nx = ST_IDLE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            wcnt   <= '0;
            rcnt   <= '0;
            skip_q <= 1'b0;
            fast_q <= 1'b0;
        end else begin
            st   <= st_nx;
            wcnt <= wcnt_nx;
            rcnt <= rcnt_nx;
            if (ctl.tx_load) begin
                skip_q <= rd_skip;
                fast_q <= fast_ta;
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        sclk   = 1'b0;
        dio_oe = 1'b0;
        irq    = 1'b0;
        busy   = 1'b1;
        unique case (st)
            ST_IDLE:     busy = 1'b0;
            ST_WR_LO:    dio_oe = 1'b1;
            ST_WR_HI: begin
                dio_oe = 1'b1;
                sclk   = 1'b1;
            end
            ST_TA_LO:    sclk = 1'b0;
            ST_TA_HI:    sclk = 1'b1;
            ST_TA_EXTRA: sclk = 1'b0;
            ST_RD_LO:    sclk = 1'b0;
            ST_RD_HI:    sclk = 1'b1;
            ST_EV_WAIT:  sclk = 1'b0;
            ST_IRQ:      irq  = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    AST_STATE_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && $past(rst_n)) |-> $stable(st)); // R10

    AST_IRQ_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && tick) |=> !irq); // R8

    AST_IRQ_AFTER_DIO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dio_in)); // R8

    AST_WR_COUNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (st == ST_WR_LO && wcnt == $past(wr_m1))); // R2

    AST_OE_DROP_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dio_oe) |-> !sclk); // R4

endmodule

// File: rtl/spi3w_tx_shift.sv
module spi3w_tx_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [WORD_W-1:0] tx_word,
    output logic              dio_out,
    output logic              tx_req
);

    localparam int PW = $clog2(WORD_W);
    localparam logic [PW-1:0] LAST_POS = PW'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [PW-1:0]     pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            pos    <= '0;
            tx_req <= 1'b0;
        end else begin
            tx_req <= 1'b0;
            if (load || (adv && pos == LAST_POS)) begin
                sh     <= tx_word;
                pos    <= '0;
                tx_req <= 1'b1;
            end else if (adv) begin
                sh  <= {sh[WORD_W-2:0], 1'b0};
                pos <= pos + 1'b1;
            end
        end
    end

    assign dio_out = sh[WORD_W-1];

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req); // R3

endmodule

// File: rtl/spi3w_rx_pack.sv
module spi3w_rx_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              bit_in,
    input  logic              flush,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push
);

    localparam int FW = $clog2(WORD_W);
    localparam logic [FW-1:0] FULL_AT = FW'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [FW-1:0]     fill;
    logic [WORD_W-1:0] sh_in;

    assign sh_in = {sh[WORD_W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            fill    <= '0;
            rx_word <= '0;
            rx_push <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            if (smp) begin
                sh <= sh_in;
                if (fill == FULL_AT) begin
                    rx_word <= sh_in;
                    rx_push <= 1'b1;
                    fill    <= '0;
                end else begin
                    fill <= fill + 1'b1;
                end
            end else if (flush && fill != '0) begin
                rx_word <= sh << (WORD_W - int'(fill));
                rx_push <= 1'b1;
                fill    <= '0;
            end
        end
    end

    AST_PUSH_CLEARS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> fill == '0); // R6

endmodule

// File: rtl/spi3w_master.sv
module spi3w_master
    import spi3w_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  wr_bits_m1,
    input  logic [CNT_W-1:0]  rd_bits_m1,
    input  logic              rd_skip,
    input  logic              fast_ta,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_req,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push,
    output logic              busy,
    output logic              irq,
    output logic              sclk,
    output logic              dio_out,
    output logic              dio_oe,
    input  logic              dio_in
);

    dp_ctl_t ctl;

    spi3w_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .start  (start),
        .wr_m1  (wr_bits_m1),
        .rd_m1  (rd_bits_m1),
        .rd_skip(rd_skip),
        .fast_ta(fast_ta),
        .dio_in (dio_in),
        .ctl    (ctl),
        .sclk   (sclk),
        .dio_oe (dio_oe),
        .irq    (irq),
        .busy   (busy)
    );

    spi3w_tx_shift #(.WORD_W(WORD_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctl.tx_load),
        .adv    (ctl.tx_adv),
        .tx_word(tx_word),
        .dio_out(dio_out),
        .tx_req (tx_req)
    );

    spi3w_rx_pack #(.WORD_W(WORD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp    (ctl.rx_smp),
        .bit_in (dio_in),
        .flush  (ctl.rx_flush),
        .rx_word(rx_word),
        .rx_push(rx_push)
    );

    AST_DOUT_STABLE_SCLK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk) && sclk && dio_oe) |-> $stable(dio_out)); // R2

endmodule

// File: tb/sim_spi3w_master.sv
module sim_spi3w_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic [11:0] wr_bits_m1 = '0;
    logic [11:0] rd_bits_m1 = '0;
    logic        rd_skip = 1'b0;
    logic        fast_ta = 1'b0;
    logic [31:0] tx_word;
    logic        tx_req, rx_push, busy, irq, sclk, dio_out, dio_oe;
    logic [31:0] rx_word;
    logic        dio_in = 1'b0;

    int n_chk = 0, n_fail = 0;
    int seed = 3;
    int tdiv = 1, tph = 0;
    int tx_idx = 0;

    always #10 clk = ~clk;

    spi3w_master u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .wr_bits_m1(wr_bits_m1), .rd_bits_m1(rd_bits_m1),
        .rd_skip(rd_skip), .fast_ta(fast_ta),
        .tx_word(tx_word), .tx_req(tx_req), .rx_word(rx_word), .rx_push(rx_push),
        .busy(busy), .irq(irq), .sclk(sclk), .dio_out(dio_out), .dio_oe(dio_oe),
        .dio_in(dio_in)
    );

    function automatic logic [31:0] txgen(int k);
        return 32'hC0DE_5A17 ^ (32'(k) * 32'h9E37_79B9) ^ (32'(seed) * 32'h0101_0101);
    endfunction

    function automatic logic txbit(int j);
        logic [31:0] wd;
        wd = txgen(j / 32);
        return wd[31 - (j % 32)];
    endfunction

    function automatic logic patbit(int i);
        return ((i * 13 + seed) % 7) < 3;
    endfunction

    function automatic logic [31:0] rx_exp(int k, int r);
        logic [31:0] v;
        v = '0;
        for (int j = 0; j < 32; j++) begin
            if (32 * k + j <= r) v[31 - j] = patbit(32 * k + j);
        end
        return v;
    endfunction

    assign tx_word = txgen(tx_idx);

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // tick strobe
    always @(negedge clk) begin
        if (tph >= tdiv - 1) begin
            tph = 0;
            tick <= 1'b1;
        end else begin
            tph++;
            tick <= 1'b0;
        end
    end

    // monitor and target model
    bit mon_en = 0;
    int cur_r = 0, cur_d = 1;
    bit cur_skip = 0;
    int wbits, wbad, oe_hi, rrises, gap, txreq_cnt, rxn, irq_hi, busy_rise;
    int hi_run, first_hi, wchg, dcnt, cyc, up_cyc, first_irq;
    bit prev_sclk, prev_oe, prev_busy, prev_dout, oe_fall_sclk, arm, up;
    logic [31:0] rxg [0:7];

    task automatic mon_clear();
        wbits = 0; wbad = 0; oe_hi = 0; rrises = 0; gap = 0; txreq_cnt = 0;
        rxn = 0; irq_hi = 0; busy_rise = 0; hi_run = 0; first_hi = 0; wchg = 0;
        dcnt = 0; cyc = 0; up_cyc = -1; first_irq = -1;
        oe_fall_sclk = 0; arm = 0; up = 0;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (tx_req) begin txreq_cnt++; tx_idx++; end
            if (rx_push) begin
                if (rxn < 8) rxg[rxn] = rx_word;
                rxn++;
            end
            if (irq) irq_hi++;
            if (irq && first_irq < 0) first_irq = cyc;
            if (busy && !prev_busy) busy_rise++;
            if (dio_oe) oe_hi++;
            if (prev_oe && !dio_oe) begin
                oe_fall_sclk = sclk;
                if (cur_skip) arm = 1;
            end
            if (sclk && !prev_sclk) begin
                if (dio_oe) begin
                    if (dio_out !== txbit(wbits)) wbad++;
                    wbits++;
                end else begin
                    rrises++;
                end
            end
            if (sclk && prev_sclk && dio_oe && dio_out !== prev_dout) wchg++;
            if (sclk) hi_run++;
            else begin
                if (prev_sclk && first_hi == 0) first_hi = hi_run;
                hi_run = 0;
            end
            if (!dio_oe && !sclk && rrises == 1 && !cur_skip) gap++;
            if (!cur_skip && rrises >= 1 && rrises <= cur_r + 1)
                dio_in = patbit(rrises - 1);
            else if (!cur_skip && rrises == cur_r + 2 && !arm) begin
                dio_in = 1'b0;
                arm = 1;
            end
            if (arm && !up) begin
                if (dcnt >= cur_d) begin
                    up = 1;
                    dio_in = 1'b1;
                    up_cyc = cyc;
                end else dcnt++;
            end
            cyc++;
        end
        prev_sclk = sclk;
        prev_oe   = dio_oe;
        prev_busy = busy;
        prev_dout = dio_out;
    end

    task automatic run(int w, int r, bit f, bit s, int d, bit poke);
        int t;
        int nw, nr;
        @(negedge clk);
        mon_clear();
        tx_idx = 0;
        dio_in = 1'b0;
        cur_r = r; cur_d = d; cur_skip = s;
        wr_bits_m1 = 12'(w); rd_bits_m1 = 12'(r);
        fast_ta = f; rd_skip = s;
        start = 1'b1;
        mon_en = 1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            wr_bits_m1 = 12'd3;
            fast_ta = ~f;
            repeat (5) @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (first_irq < 0 && t < 20000) begin @(negedge clk); t++; end
        repeat (20 + 4 * tdiv) @(negedge clk);
        mon_en = 0;
        nw = (w + 1 + 31) / 32;
        nr = s ? 0 : (r + 1 + 31) / 32;
        chk(first_irq >= 0, "R8", "irq seen", first_irq, 0);
        chk(wbits == w + 1, "R2", "write bit count", wbits, w + 1);
        chk(wbad == 0, "R2", "write bit mismatches", wbad, 0);
        chk(wchg == 0, "R2", "dout change while sclk high", wchg, 0);
        chk(oe_hi == 2 * (w + 1) * tdiv, "R2", "oe high cycles", oe_hi, 2 * (w + 1) * tdiv);
        chk(txreq_cnt == nw, "R3", "tx_req pulses", txreq_cnt, nw);
        chk(oe_fall_sclk == 0, "R4", "sclk at oe release", oe_fall_sclk, 0);
        if (s) begin
            chk(rrises == 0, "R7", "read-phase sclk rises", rrises, 0);
            chk(rxn == 0, "R7", "rx pushes", rxn, 0);
        end else begin
            chk(gap == (f ? 2 : 1) * tdiv, "R4", "turnaround low gap", gap, (f ? 2 : 1) * tdiv);
            chk(rrises == r + 2, "R5", "read sclk rises incl turnaround", rrises, r + 2);
            chk(rxn == nr, "R6", "rx word count", rxn, nr);
            for (int k = 0; k < nr && k < 8; k++)
                chk(rxg[k] == rx_exp(k, r), "R6", "rx word value", rxg[k], rx_exp(k, r));
        end
        chk(irq_hi == tdiv, "R8", "irq width cycles", irq_hi, tdiv);
        if (tdiv == 1)
            chk(first_irq - up_cyc == 1, "R8", "irq latency", first_irq - up_cyc, 1);
        chk(first_hi == tdiv, "R10", "sclk high cycles", first_hi, tdiv);
        chk(busy_rise == 1, "R9", "transactions started", busy_rise, 1);
        chk(!busy && !sclk && !dio_oe && !irq, "R1", "idle outputs after run",
            {busy, sclk, dio_oe, irq}, 0);
    endtask

    // watchdog
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 180000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", wd_cnt, 180000);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    int ws [6] = '{0, 1, 7, 31, 32, 45};
    int rs [5] = '{0, 2, 31, 32, 40};

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !sclk && !dio_oe && !irq && !tx_req && !rx_push, "R1",
            "outputs in reset", {busy, sclk, dio_oe, irq}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !sclk && !dio_oe && !irq, "R1", "outputs after reset",
            {busy, sclk, dio_oe, irq}, 0);
        // sweep of lengths and both turnaround modes
        foreach (ws[i]) begin
            foreach (rs[j]) begin
                for (int f = 0; f < 2; f++) begin
                    seed = i * 5 + j + f;
                    run(ws[i], rs[j], f[0], 1'b0, (ws[i] + rs[j]) % 5 + 1, 1'b0);
                end
            end
        end
        // read skip
        run(0, 9, 1'b0, 1'b1, 2, 1'b0);  // R7
        run(33, 9, 1'b1, 1'b1, 4, 1'b0); // R7
        // start held while busy
        run(40, 20, 1'b0, 1'b0, 3, 1'b1); // R9
        // slowed tick
        tdiv = 3;
        run(9, 35, 1'b1, 1'b0, 2, 1'b0); // R10
        run(33, 4, 1'b0, 1'b0, 5, 1'b0); // R10
        tdiv = 1;
        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule